// File: doc/BRIEF.md
# Text Cursor Generator with Blink

This block makes the cursor signal of a character-cell display controller. The raster logic supplies the refresh address of the current character cell. It also supplies the scan row being drawn, the row that takes over after the line ends, a one-cycle end-of-line strobe and a free-running frame count. The cursor generator holds one bit of state, the cursor-line flag, which says whether the current scan row lies inside the cursor's vertical window. At each end-of-line strobe it updates that flag from the programmed first and last cursor rows, then applies the selected blink behaviour to it.

The cursor output is combinational from the flag and an address comparison. It is therefore valid in the same cycle as the refresh address it belongs to, and the pixel logic can merge it with the character data of that cell without adding a delay stage. A build-time parameter removes the generator completely, and the output is then held low.

Top module: `cursor_gen`

## Requirements
- R1: `cursor_o` is high in a cycle exactly when the cursor-line flag is set and `refresh_addr_i` equals `cur_addr_i` in that same cycle. There is no register between those inputs and the output.
- R2: On a clock edge with `line_end_i` high, a set flag is cleared when `row_now_i` equals `cur_last_row_i`, unless R3 or the blink mode sets it again.
- R3: On a clock edge with `line_end_i` high, the flag is set when `row_next_i` equals `cur_first_row_i`. This takes priority over the clear in R2, and the result then passes through the blink mode.
- R4: On a clock edge with `line_end_i` low, the flag keeps its value whatever the row, address, frame and mode inputs are.
- R5: With `blink_mode_i` = 2'b00 (slow symmetric blink), the flag that results from R2/R3 is kept only if bit 3 of `frame_i` is 1 at that end of line. This gives 8 frames on and 8 frames off.
- R6: With `blink_mode_i` = 2'b01 (hidden), every end of line clears the flag.
- R7: With `blink_mode_i` = 2'b10 (steady), every end of line sets the flag, whatever the rows are.
- R8: With `blink_mode_i` = 2'b11 (brief flash), the flag that results from R2/R3 is kept only if bits 3:2 of `frame_i` are both 0 at that end of line. This gives 4 frames on out of every 16.
- R9: While `rst_n` is low, the flag is cleared, so `cursor_o` is low.
- R10: When the parameter `CURSOR_EN` is 0, `cursor_o` is low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_addr_i | input | ADDR_W (14) | Refresh address of the current character cell |
| row_now_i | input | ROW_W (5) | Scan row being drawn in this cycle |
| row_next_i | input | ROW_W (5) | Scan row that applies after the current line ends |
| line_end_i | input | 1 | One-cycle strobe on the last character of a line |
| frame_i | input | FRAME_W (6) | Frame counter from the raster logic |
| cur_addr_i | input | ADDR_W (14) | Cursor address register |
| cur_first_row_i | input | ROW_W (5) | First scan row of the cursor |
| cur_last_row_i | input | ROW_W (5) | Last scan row of the cursor |
| blink_mode_i | input | 2 | Blink mode: 00 slow, 01 hidden, 10 steady, 11 brief |
| cursor_o | output | 1 | Cursor output for the current cell |

## Verification
The assertions check every cycle that the output never rises without an address match and a set flag. They also check that the flag is stable between line ends, that the hidden and steady modes force the flag on the next edge, and that each blink gate clears the flag in its off phase. What a gate does in its on phase depends on how the row window and its priority evolve over many lines, and only the bench scenarios show that. The same holds for the reset release and the disabled build, which the bench compares against its own line-by-line model of the flag.

// File: rtl/cursor_gen_pkg.sv
package cursor_gen_pkg;

  typedef enum logic [1:0] {
    BLINK_SLOW   = 2'b00,
    BLINK_HIDE   = 2'b01,
    BLINK_STEADY = 2'b10,
    BLINK_BRIEF  = 2'b11
  } blink_mode_t;

  // Row window step: opening wins over closing.
  function automatic logic window_step(input logic flag_q,
                                       input logic closing,
                                       input logic opening);
    logic kept;
    kept = flag_q & ~closing;
    return kept | opening;
  endfunction

  // Blink gate applied to the stepped window value.
  // tap_hi is the frame bit at the blink tap, tap_lo the bit just below it.
  function automatic logic blink_apply(input blink_mode_t mode,
                                       input logic        win,
                                       input logic        tap_hi,
                                       input logic        tap_lo);
    logic res;
    unique case (mode)
      BLINK_SLOW:   res = win & tap_hi;
      BLINK_HIDE:   res = 1'b0;
      BLINK_STEADY: res = 1'b1;
      BLINK_BRIEF:  res = win & ~tap_hi & ~tap_lo;
      default:      res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cursor_row_window.sv
module cursor_row_window #(
  parameter int ROW_W = 5
) (
  input  logic [ROW_W-1:0] row_now_i,
  input  logic [ROW_W-1:0] row_next_i,
  input  logic [ROW_W-1:0] first_row_i,
  input  logic [ROW_W-1:0] last_row_i,
  output logic             closing_o,
  output logic             opening_o
);
  assign closing_o = (row_now_i == last_row_i);
  assign opening_o = (row_next_i == first_row_i);
endmodule

// File: rtl/cursor_blink_gate.sv
module cursor_blink_gate #(
  parameter int FRAME_W   = 6,
  parameter int BLINK_TAP = 3
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [1:0]         mode_i,
  input  logic               win_i,
  output logic               gated_o
);
  import cursor_gen_pkg::*;

  localparam int TAP_LO = BLINK_TAP - 1;

  blink_mode_t mode;
  assign mode    = blink_mode_t'(mode_i);
  assign gated_o = blink_apply(mode, win_i, frame_i[BLINK_TAP], frame_i[TAP_LO]);
endmodule

// File: rtl/cursor_line_flag.sv
module cursor_line_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/cursor_gen.sv
module cursor_gen #(
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 5,
  parameter int FRAME_W   = 6,
  parameter int BLINK_TAP = 3,
  parameter bit CURSOR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] refresh_addr_i,
  input  logic [ROW_W-1:0]  row_now_i,
  input  logic [ROW_W-1:0]  row_next_i,
  input  logic              line_end_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [ROW_W-1:0]  cur_first_row_i,
  input  logic [ROW_W-1:0]  cur_last_row_i,
  input  logic [1:0]        blink_mode_i,
  output logic              cursor_o
);
  import cursor_gen_pkg::*;

  // Named internal events, observed by the bound checker.
  logic line_flag;
  logic win_close;
  logic win_open;
  logic win_next;
  logic flag_next;
  logic addr_hit;

  generate
    if (CURSOR_EN) begin : g_on
      cursor_row_window #(.ROW_W(ROW_W)) u_window (
        .row_now_i   (row_now_i),
        .row_next_i  (row_next_i),
        .first_row_i (cur_first_row_i),
        .last_row_i  (cur_last_row_i),
        .closing_o   (win_close),
        .opening_o   (win_open)
      );

      assign win_next = window_step(line_flag, win_close, win_open);

      cursor_blink_gate #(.FRAME_W(FRAME_W), .BLINK_TAP(BLINK_TAP)) u_gate (
        .frame_i (frame_i),
        .mode_i  (blink_mode_i),
        .win_i   (win_next),
        .gated_o (flag_next)
      );

      cursor_line_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (line_end_i),
        .d_i    (flag_next),
        .q_o    (line_flag)
      );

      assign addr_hit = (refresh_addr_i == cur_addr_i);
      assign cursor_o = line_flag & addr_hit;
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, refresh_addr_i, row_now_i, row_next_i,
                               line_end_i, frame_i, cur_addr_i, cur_first_row_i,
                               cur_last_row_i, blink_mode_i};
      assign win_close = 1'b0;
      assign win_open  = 1'b0;
      assign win_next  = 1'b0;
      assign flag_next = 1'b0;
      assign line_flag = 1'b0;
      assign addr_hit  = 1'b0;
      assign cursor_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cursor_gen_chk.sv
module cursor_gen_chk #(
  parameter int ADDR_W    = 14,
  parameter int ROW_W     = 5,
  parameter int FRAME_W   = 6,
  parameter int BLINK_TAP = 3,
  parameter bit CURSOR_EN = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  refresh_addr_i,
  input logic [ADDR_W-1:0]  cur_addr_i,
  input logic               line_end_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [1:0]         blink_mode_i,
  input logic               line_flag,
  input logic               cursor_o
);
  localparam int TAP_LO = BLINK_TAP - 1;

  generate
    if (CURSOR_EN) begin : g_chk
      // R1: output needs both the flag and a matching address
      p_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_o |-> (line_flag && refresh_addr_i == cur_addr_i));

      // R4: flag only moves on an end-of-line edge
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end_i |=> $stable(line_flag));

      // R5: slow blink off phase clears the flag
      p_slow_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && blink_mode_i == 2'b00 && !frame_i[BLINK_TAP]) |=> !line_flag);

      // R6: hidden mode
      p_hide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && blink_mode_i == 2'b01) |=> !line_flag);

      // R7: steady mode
      p_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && blink_mode_i == 2'b10) |=> line_flag);

      // R8: brief flash off phase clears the flag
      p_brief_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && blink_mode_i == 2'b11 &&
         (frame_i[BLINK_TAP] || frame_i[TAP_LO])) |=> !line_flag);
    end else begin : g_chk_off
      // R10: disabled build never drives the cursor
      p_disabled_low_r10: assert property (@(posedge clk) !cursor_o);
    end
  endgenerate
endmodule

bind cursor_gen cursor_gen_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .FRAME_W(FRAME_W),
  .BLINK_TAP(BLINK_TAP), .CURSOR_EN(CURSOR_EN)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .refresh_addr_i (refresh_addr_i),
  .cur_addr_i     (cur_addr_i),
  .line_end_i     (line_end_i),
  .frame_i        (frame_i),
  .blink_mode_i   (blink_mode_i),
  .line_flag      (line_flag),
  .cursor_o       (cursor_o)
);

// File: tb/tb_cursor_gen.sv
module tb_cursor_gen;
  localparam int AW = 14;
  localparam int RW = 5;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic [RW-1:0] rnow = '0;
  logic [RW-1:0] rnext = '0;
  logic          eol = 1'b0;
  logic [FW-1:0] frame = '0;
  logic [AW-1:0] caddr = 14'h0123;
  logic [RW-1:0] first_row = 5'd2;
  logic [RW-1:0] last_row = 5'd4;
  logic [1:0]    mode = 2'b10;
  logic          cur;
  logic          cur_off;

  int checks = 0;
  int errors = 0;
  logic model = 1'b0;

  always #10 clk = ~clk;

  cursor_gen dut (
    .clk(clk), .rst_n(rst_n), .refresh_addr_i(raddr), .row_now_i(rnow),
    .row_next_i(rnext), .line_end_i(eol), .frame_i(frame), .cur_addr_i(caddr),
    .cur_first_row_i(first_row), .cur_last_row_i(last_row),
    .blink_mode_i(mode), .cursor_o(cur)
  );

  cursor_gen #(.CURSOR_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .refresh_addr_i(raddr), .row_now_i(rnow),
    .row_next_i(rnext), .line_end_i(eol), .frame_i(frame), .cur_addr_i(caddr),
    .cur_first_row_i(first_row), .cur_last_row_i(last_row),
    .blink_mode_i(mode), .cursor_o(cur_off)
  );

  // Expected flag after an edge, written mode-first from the requirements.
  function automatic logic model_next(logic f, logic e, logic [RW-1:0] rn,
                                      logic [RW-1:0] rx, logic [RW-1:0] s,
                                      logic [RW-1:0] t, logic [1:0] m,
                                      logic [FW-1:0] fr);
    logic w;
    if (!e) return f;                        // R4
    if (m == 2'b01) return 1'b0;             // R6
    if (m == 2'b10) return 1'b1;             // R7
    w = f;
    if (rn == t) w = 1'b0;                   // R2
    if (rx == s) w = 1'b1;                   // R3 wins
    if (m == 2'b00) return w && fr[3];       // R5
    return w && (fr[3:2] == 2'b00);          // R8
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Inputs already driven after a negedge; check outputs, then take one edge.
  task automatic step(string req);
    #2;
    check(req, cur, model && (raddr == caddr));
    check("R10", cur_off, 1'b0);
    @(posedge clk);
    model = model_next(model, eol, rnow, rnext, first_row, last_row, mode, frame);
    @(negedge clk);
  endtask

  task automatic drive(logic e, logic [RW-1:0] rn, logic [RW-1:0] rx,
                       logic [1:0] m, logic [FW-1:0] fr, logic [AW-1:0] a);
    eol = e; rnow = rn; rnext = rx; mode = m; frame = fr; raddr = a;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R9: reset state
    #2;
    check("R9", cur, 1'b0);
    raddr = caddr;
    #1;
    check("R9", cur, 1'b0);
    rst_n = 1'b1;
    model = 1'b0;
    @(negedge clk);

    // R7 then R1 address match / mismatch
    drive(1'b1, 5'd9, 5'd10, 2'b10, 6'd0, caddr); step("R7");
    drive(1'b0, 5'd10, 5'd11, 2'b10, 6'd0, caddr); step("R1");
    drive(1'b0, 5'd10, 5'd11, 2'b10, 6'd0, caddr ^ 14'h1); step("R1");
    // R6 hide
    drive(1'b1, 5'd10, 5'd11, 2'b01, 6'd0, caddr); step("R6");
    drive(1'b0, 5'd11, 5'd12, 2'b01, 6'd0, caddr); step("R6");
    // R3 open (brief mode, frame 0 -> allowed), R4 hold with noise
    drive(1'b1, 5'd1, 5'd2, 2'b11, 6'd0, caddr); step("R3");
    drive(1'b0, 5'd4, 5'd0, 2'b01, 6'd12, caddr); step("R4");
    // R2 close
    drive(1'b1, 5'd4, 5'd5, 2'b11, 6'd0, caddr); step("R2");
    drive(1'b0, 5'd5, 5'd6, 2'b11, 6'd0, caddr); step("R2");
    // R3 priority over R2: last row equals row_now and first row equals row_next
    drive(1'b1, 5'd4, 5'd2, 2'b00, 6'd8, caddr); step("R3");
    drive(1'b0, 5'd2, 5'd3, 2'b00, 6'd8, caddr); step("R3");
    // R5 slow blink off phase
    drive(1'b1, 5'd2, 5'd3, 2'b00, 6'd7, caddr); step("R5");
    drive(1'b0, 5'd3, 5'd3, 2'b00, 6'd7, caddr); step("R5");
    // R8 brief off phase after reopening
    drive(1'b1, 5'd1, 5'd2, 2'b11, 6'd4, caddr); step("R8");
    drive(1'b0, 5'd2, 5'd3, 2'b11, 6'd4, caddr); step("R8");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ((i % 200) == 0) begin
        first_row = 5'($urandom_range(0, 7));
        last_row  = 5'($urandom_range(0, 7));
        caddr     = 14'($urandom);
      end
      drive(($urandom_range(0, 3) == 0),
            5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
            2'($urandom), 6'($urandom),
            ($urandom_range(0, 1) == 1) ? caddr : 14'($urandom));
      step("R1");
    end

    // R9: reset mid-run clears the flag
    drive(1'b1, 5'd0, 5'd1, 2'b10, 6'd0, caddr); step("R7");
    rst_n = 1'b0;
    #2;
    check("R9", cur, 1'b0);
    model = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 5'd0, 5'd1, 2'b10, 6'd0, caddr); step("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule